// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Unit

This block is a small performance-monitoring unit with a parameterised set of event counters (four by default). The core feeds it one pulse line per event kind, active for each cycle in which that event occurs, and a single bit giving the current privilege level (0 for user, 1 for kernel). Each counter has its own type register. That register picks one event line and holds two filter bits that allow counting at user level, at kernel level, at both levels or at neither.

Software reaches the unit over a simple single-cycle register bus with separate read and write strobes and a shared byte address. The control register holds a master run bit and a self-clearing zero-all bit. Two mask registers set and clear the per-counter enables, one bit per counter. A fixed identification word reports the monitor version. Each counter value can also be written directly.

Counters are 32 bits wide and wrap to zero on overflow.

Top module: `evcnt_unit`

Register map (byte addresses): control 0x00 (bit 0 run, bit 1 zero-all), enable-set 0x04, enable-clear 0x08, identification 0x0C, counter n value at 0x40+4n, counter n type at 0x80+4n. The type word holds the event select in bits [3:0], the user-allow bit in bit 30 and the kernel-allow bit in bit 31. Unmapped addresses read as 0.

## Requirements
- R1: After reset all counters, type registers, enables and the run bit read as 0.
- R2: A counter advances by exactly one on a clock edge only when all of these hold in that cycle: the run bit is 1, its own enable is 1, its selected event line is high, and the allow bit for the current privilege level is 1. Otherwise it holds its value.
- R3: With the privilege input at 1 (kernel), the kernel-allow bit (type bit 31) decides whether events count: 1 counts them, 0 ignores them.
- R4: With the privilege input at 0 (user), the user-allow bit (type bit 30) decides whether events count: 1 counts them, 0 ignores them.
- R5: The event select (type bits [3:0]) picks which event input line the counter follows. Other lines have no effect on that counter.
- R6: Writing the enable-set register (0x04) sets enable n for each 1 in bit n. Zero bits leave the enables unchanged. Reading 0x04 returns the current enable mask.
- R7: Writing the enable-clear register (0x08) clears enable n for each 1 in bit n. Zero bits leave the enables unchanged. Reading 0x08 returns the current enable mask.
- R8: While the run bit (control bit 0) is 0, no counter advances, whatever the enables are.
- R9: A control write with bit 1 set zeroes every counter on that edge. The zeroing takes priority over a same-cycle increment. Bit 1 always reads back as 0.
- R10: A write to a counter address loads that counter. Incrementing from 0xFFFFFFFF gives 0.
- R11: The identification register (0x0C) reads 0x05000000: the monitor version 0x5 sits in bits [27:24]. Writes to it have no effect.
- R12: A read strobe in cycle t returns, after the edge that ends cycle t, the register contents as they were before that edge. The read data then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_EVT | Per-cycle event pulses |
| priv_i | input | 1 | Current privilege: 0 user, 1 kernel |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
Each counter and control register changes on the edge that samples its write or event. Read data appears one edge after the read strobe and shows the state from before that edge. The bench drives every input at the falling edge and steps a behavioural model once per rising edge. It computes each read's expected word from the model before that model step, then compares the returned word at the next falling edge. This covers same-cycle races such as a zero-all arriving together with an event, and a read arriving together with a load to the same address.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  // byte offsets of the register file
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_EN_SET  = 'h04;
  localparam int OFS_EN_CLR  = 'h08;
  localparam int OFS_IDENT   = 'h0C;
  localparam int OFS_CNT_BASE = 'h40;
  localparam int OFS_TYP_BASE = 'h80;
  localparam int REG_STRIDE  = 4;

  // field positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_ZERO_BIT = 1;
  localparam int TYP_USER_BIT  = 30;
  localparam int TYP_KERN_BIT  = 31;
  localparam int IDENT_LO      = 24;
  localparam logic [3:0] MON_VERSION = 4'h5;

  typedef enum logic {PRIV_USER = 1'b0, PRIV_KERN = 1'b1} priv_e;
endpackage

// File: rtl/evcnt_filter.sv
module evcnt_filter #(
  parameter int NUM_EVT = 16,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               user_ok_i,
  input  logic               kern_ok_i,
  input  logic               priv_i,
  input  logic               run_i,
  output logic               hit_o
);
  import evcnt_pkg::*;

  logic evt_sel;
  logic priv_ok;

  always_comb begin
    evt_sel = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel_i == SEL_W'(k)) evt_sel = evt_i[k];
    end
  end

  assign priv_ok = (priv_e'(priv_i) == PRIV_KERN) ? kern_ok_i : user_ok_i;
  assign hit_o   = run_i & evt_sel & priv_ok;
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             typ_we_i,
  input  logic [SEL_W-1:0] typ_sel_i,
  input  logic             typ_user_i,
  input  logic             typ_kern_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             user_o,
  output logic             kern_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (zero_i)   cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (inc_i)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      user_o <= 1'b0;
      kern_o <= 1'b0;
    end else if (typ_we_i) begin
      sel_o  <= typ_sel_i;
      user_o <= typ_user_i;
      kern_o <= typ_kern_i;
    end
  end

  assign cnt_o = cnt_q;

  // R9: zeroing overrides any same-cycle load or increment
  a_r9_zero_wins: assert property (@(posedge clk) disable iff (rst)
    zero_i |=> (cnt_q == '0));

  // R10: increment steps by one and wraps
  a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !zero_i && !cnt_we_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: no qualifying event, no change
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !zero_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evcnt_regs.sv
module evcnt_regs #(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr_en,
  input  logic                          bus_rd_en,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals_i,
  input  logic [NUM_CNT-1:0][SEL_W-1:0] sel_vals_i,
  input  logic [NUM_CNT-1:0]            user_vals_i,
  input  logic [NUM_CNT-1:0]            kern_vals_i,
  output logic                          run_o,
  output logic [NUM_CNT-1:0]            en_o,
  output logic                          zero_o,
  output logic [NUM_CNT-1:0]            cnt_we_o,
  output logic [NUM_CNT-1:0]            typ_we_o,
  output logic [DATA_W-1:0]             bus_rdata
);
  import evcnt_pkg::*;

  logic              hit_ctrl, hit_set, hit_clr, hit_ident;
  logic [NUM_CNT-1:0] hit_cnt, hit_typ;
  logic [NUM_CNT-1:0] wmask;
  logic              run_q;
  logic [NUM_CNT-1:0] en_q;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_set   = (bus_addr == ADDR_W'(OFS_EN_SET));
  assign hit_clr   = (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign hit_ident = (bus_addr == ADDR_W'(OFS_IDENT));
  assign wmask     = bus_wdata[NUM_CNT-1:0];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_dec
    localparam logic [ADDR_W-1:0] CNT_ADR = ADDR_W'(OFS_CNT_BASE + REG_STRIDE * n);
    localparam logic [ADDR_W-1:0] TYP_ADR = ADDR_W'(OFS_TYP_BASE + REG_STRIDE * n);
    assign hit_cnt[n]  = (bus_addr == CNT_ADR);
    assign hit_typ[n]  = (bus_addr == TYP_ADR);
    assign cnt_we_o[n] = bus_wr_en & hit_cnt[n];
    assign typ_we_o[n] = bus_wr_en & hit_typ[n];
  end

  assign zero_o = bus_wr_en & hit_ctrl & bus_wdata[CTRL_ZERO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      en_q  <= '0;
    end else if (bus_wr_en) begin
      if (hit_ctrl) run_q <= bus_wdata[CTRL_RUN_BIT];
      if (hit_set)  en_q  <= en_q | wmask;
      if (hit_clr)  en_q  <= en_q & ~wmask;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)            rd_mux[CTRL_RUN_BIT] = run_q;
    if (hit_set || hit_clr)  rd_mux[NUM_CNT-1:0]  = en_q;
    if (hit_ident)           rd_mux[IDENT_LO+3:IDENT_LO] = MON_VERSION;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (hit_cnt[n]) rd_mux = DATA_W'(cnt_vals_i[n]);
      if (hit_typ[n]) begin
        rd_mux[SEL_W-1:0]    = sel_vals_i[n];
        rd_mux[TYP_USER_BIT] = user_vals_i[n];
        rd_mux[TYP_KERN_BIT] = kern_vals_i[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  assign run_o = run_q;
  assign en_o  = en_q;

  // R6: every 1 written to the set register appears in the mask
  a_r6_set_lands: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && hit_set) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R7: every 1 written to the clear register removes that enable
  a_r7_clr_lands: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && hit_clr) |=> ((en_q & $past(wmask)) == '0));

  // R6/R7: the mask moves only through the two mask registers
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_en && (hit_set || hit_clr)) |=> $stable(en_q));

  // R11: identification read returns the version nibble
  a_r11_ident: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && hit_ident) |=> (bus_rdata[IDENT_LO+3:IDENT_LO] == MON_VERSION));

  // R12: read data holds between reads
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 16,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               priv_i,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata
);
  import evcnt_pkg::*;

  localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic                          run;
  logic [NUM_CNT-1:0]            en;
  logic                          zero;
  logic [NUM_CNT-1:0]            cnt_we, typ_we, inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vals;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_vals;
  logic [NUM_CNT-1:0]            user_vals, kern_vals;

  evcnt_regs #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_vals_i(cnt_vals), .sel_vals_i(sel_vals),
    .user_vals_i(user_vals), .kern_vals_i(kern_vals),
    .run_o(run), .en_o(en), .zero_o(zero),
    .cnt_we_o(cnt_we), .typ_we_o(typ_we),
    .bus_rdata(bus_rdata)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    evcnt_filter #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_filt (
      .evt_i(evt_i), .sel_i(sel_vals[n]),
      .user_ok_i(user_vals[n]), .kern_ok_i(kern_vals[n]),
      .priv_i(priv_i), .run_i(run & en[n]),
      .hit_o(inc[n])
    );

    evcnt_slice #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_slice (
      .clk(clk), .rst(rst), .zero_i(zero),
      .cnt_we_i(cnt_we[n]), .cnt_wdata_i(bus_wdata[CNT_W-1:0]),
      .typ_we_i(typ_we[n]), .typ_sel_i(bus_wdata[SEL_W-1:0]),
      .typ_user_i(bus_wdata[TYP_USER_BIT]), .typ_kern_i(bus_wdata[TYP_KERN_BIT]),
      .inc_i(inc[n]),
      .cnt_o(cnt_vals[n]), .sel_o(sel_vals[n]),
      .user_o(user_vals[n]), .kern_o(kern_vals[n])
    );

    // R8: with the run bit low this counter cannot move by counting
    a_r8_run_gate: assert property (@(posedge clk) disable iff (rst)
      (!run && !zero && !cnt_we[n]) |=> $stable(cnt_vals[n]));
  end
endmodule

// File: tb/evcnt_unit_bench.sv
module evcnt_unit_bench;
  localparam int N = 4;
  localparam int E = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [E-1:0] evt = '0;
  logic        priv = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_cnt [N];
  logic [3:0]  m_sel [N];
  logic        m_uf [N], m_kf [N];
  logic [N-1:0] m_en;
  logic        m_run;

  always #5 clk = ~clk;

  evcnt_unit u_evcnt_unit (
    .clk(clk), .rst(rst), .evt_i(evt), .priv_i(priv),
    .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata)
  );

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'h00) v[0] = m_run;
    if (a == 8'h04 || a == 8'h08) v[N-1:0] = m_en;
    if (a == 8'h0C) v = 32'h0500_0000;
    for (int n = 0; n < N; n++) begin
      if (a == 8'(8'h40 + 4*n)) v = m_cnt[n];
      if (a == 8'(8'h80 + 4*n)) v = {m_kf[n], m_uf[n], 26'd0, m_sel[n]};
    end
    return v;
  endfunction

  task automatic m_step();
    bit zero = wr && addr == 8'h00 && wdata[1];
    for (int n = 0; n < N; n++) begin
      bit inc = m_run && m_en[n] && evt[m_sel[n]] && (priv ? m_kf[n] : m_uf[n]);
      if (zero) m_cnt[n] = '0;
      else if (wr && addr == 8'(8'h40 + 4*n)) m_cnt[n] = wdata;
      else if (inc) m_cnt[n] = m_cnt[n] + 32'd1;
      if (wr && addr == 8'(8'h80 + 4*n)) begin
        m_sel[n] = wdata[3:0]; m_uf[n] = wdata[30]; m_kf[n] = wdata[31];
      end
    end
    if (wr && addr == 8'h00) m_run = wdata[0];
    if (wr && addr == 8'h04) m_en = m_en | wdata[N-1:0];
    if (wr && addr == 8'h08) m_en = m_en & ~wdata[N-1:0];
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input bit r, input bit w, input logic [7:0] a,
                     input logic [31:0] d, input logic [E-1:0] ev,
                     input bit pk, input string tag);
    logic [31:0] exp_v;
    rd = r; wr = w; addr = a; wdata = d; evt = ev; priv = pk;
    exp_v = m_read(a);
    @(posedge clk);
    m_step();
    @(negedge clk);
    if (r) begin
      total++;
      if (rdata !== exp_v) begin
        bad++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag, a, rdata, exp_v);
      end
    end
    rd = 0; wr = 0; evt = '0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    cyc(0, 1, a, d, '0, 0, "");
  endtask

  task automatic rd_reg(input logic [7:0] a, input string tag);
    cyc(1, 0, a, '0, '0, 0, tag);
  endtask

  task automatic rd_all_cnt(input string tag);
    for (int n = 0; n < N; n++) rd_reg(8'(8'h40 + 4*n), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      m_cnt[n] = '0; m_sel[n] = '0; m_uf[n] = 0; m_kf[n] = 0;
    end
    m_en = '0; m_run = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state of every register
    total++;
    if (rdata !== 32'h0) begin
      bad++; $display("FAIL R1 rdata after reset actual=%08h expected=00000000", rdata);
    end
    rd_reg(8'h00, "R1"); rd_reg(8'h04, "R1");
    for (int n = 0; n < N; n++) rd_reg(8'(8'h80 + 4*n), "R1");
    rd_all_cnt("R1");

    // R11: identification value and read-only behaviour
    rd_reg(8'h0C, "R11");
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_reg(8'h0C, "R11");

    // types: c0 ev3 both, c1 ev5 user, c2 ev5 kernel, c3 ev7 none
    wr_reg(8'h80, 32'hC000_0003);
    wr_reg(8'h84, 32'h4000_0005);
    wr_reg(8'h88, 32'h8000_0005);
    wr_reg(8'h8C, 32'h0000_0007);
    for (int n = 0; n < N; n++) rd_reg(8'(8'h80 + 4*n), "R5");

    // R6: set mask, zero bits leave it
    wr_reg(8'h04, 32'h5);
    wr_reg(8'h04, 32'h2);
    rd_reg(8'h04, "R6");
    wr_reg(8'h04, 32'h0);
    rd_reg(8'h04, "R6");
    wr_reg(8'h04, 32'h8);
    rd_reg(8'h08, "R7");

    // R8: run bit low, events on every line
    for (int i = 0; i < 6; i++) cyc(0, 0, 8'h00, '0, '1, i[0], "");
    rd_all_cnt("R8");

    wr_reg(8'h00, 32'h1);
    rd_reg(8'h00, "R8");

    // R4: user level, event 5 only -> counter 1 counts, counter 2 not
    for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, '0, 16'h0020, 0, "");
    rd_all_cnt("R4");
    // R3: kernel level, event 5 only -> counter 2 counts, counter 1 not
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, '0, 16'h0020, 1, "");
    rd_all_cnt("R3");
    // R5: lines other than the selected one do nothing
    for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, '0, 16'hFF57, i[0], "");
    rd_all_cnt("R5");

    // R2: mixed traffic with a read every cycle
    for (int i = 0; i < 400; i++)
      cyc(1, 0, 8'(8'h40 + 4*(i % N)), '0, E'($urandom), 1'($urandom), "R2");

    // R7: clear enable of counter 0, zero bits ignored
    wr_reg(8'h08, 32'h1);
    wr_reg(8'h08, 32'h0);
    rd_reg(8'h08, "R7");
    for (int i = 0; i < 40; i++)
      cyc(1, 0, 8'(8'h40 + 4*(i % N)), '0, E'($urandom), 1'($urandom), "R7");

    // R9: zero-all together with qualifying events, bit reads back 0
    wr_reg(8'h04, 32'hF);
    cyc(0, 1, 8'h00, 32'h3, '1, 1, "");
    rd_all_cnt("R9");
    rd_reg(8'h00, "R9");

    // R10: direct load, read in the load cycle, then wrap
    cyc(1, 1, 8'h40, 32'hFFFF_FFFF, '0, 0, "R12");
    rd_reg(8'h40, "R10");
    cyc(0, 0, 8'h00, '0, 16'h0008, 1, "");
    rd_reg(8'h40, "R10");
    wr_reg(8'h44, 32'h1234_5678);
    rd_reg(8'h44, "R10");

    // R12: read data holds after a read
    rd_reg(8'h0C, "R12");
    repeat (3) @(negedge clk);
    total++;
    if (rdata !== 32'h0500_0000) begin
      bad++; $display("FAIL R12 hold actual=%08h expected=05000000", rdata);
    end

    finish_run();
  end
endmodule